// File: doc/BRIEF.md
# Bisync Transmit Framer

This block turns a stream of host bytes into a byte-synchronous character stream for a binary-synchronous link. Bytes arrive from a transmit FIFO through a valid/ready pair, each tagged with an end-of-frame flag. The output is one byte per accepted handshake. It goes to a serializer that does the bit-level line coding. Between frames the line carries an idle character. Once a frame is pending, the framer emits optional leading pads, a pair of SYN characters and then the host bytes.

While the data passes through, the framer classifies the frame from its content. Accumulation of the block check character starts after the first SOH or STX. SYN characters inside the data are sent but left out of the check. The frame is closed according to its last character: either the check character plus a trailing pad, or the trailing pad alone. An abort strobe ends a frame in progress with EOT and a trailing pad.

Configuration inputs select the following:
- SYN idle or mark idle
- the number of leading pads and their value
- the ASCII or EBCDIC control codes
- a two-byte CRC-16 or a one-byte LRC check

These inputs are expected to stay constant while a frame is in progress.

Top module: `bsc_tx_framer`

## Requirements
- R1: While rst_n is low (synchronous, active low), out_valid and in_ready are 0 one edge later. After reset is released, out_valid is 1 and stays 1.
- R2: With no frame in progress, out_data is the idle byte. This is the SYN code when cfg_idle_syn=1 and 0xFF (mark) when cfg_idle_syn=0.
- R3: In mark idle, cfg_pad_cnt leading pads precede the SYN pair. Each pad is 0xAA when cfg_pad_zero=0 and 0x00 when cfg_pad_zero=1. In SYN idle no pads are sent, whatever cfg_pad_cnt holds.
- R4: A frame starts when an idle byte is handed over while in_valid=1. After any pads come two SYN codes, then the FIFO bytes in order. in_ready is 1 only in the data phase together with out_ready. A byte taken from the FIFO is the byte sent in that cycle. If the FIFO runs empty within a frame, SYN fill bytes are sent.
- R5: The check starts after the first data byte equal to SOH (0x01) or STX (0x02), and that byte is not included. Every later byte up to and including the end-of-frame byte is included, except bytes equal to the SYN code.
- R6: With cfg_lrc=1 the check is one byte: the XOR of the included bytes.
- R7: With cfg_lrc=0 the check is CRC-16 with polynomial x^16+x^15+x^2+1. It is processed LSB first (reflected constant 0xA001) with a zero preset, and sent as two bytes, low byte first.
- R8: The end-of-frame byte decides the ending. If it is EOT or ENQ, or if no SOH/STX came before it, only the trailing pad 0xFF follows. Otherwise the check byte(s) and then 0xFF follow. After that the line returns to idle.
- R9: The control codes depend on cfg_ebcdic. With cfg_ebcdic=0 they are SYN=0x16, EOT=0x04, ENQ=0x05. With cfg_ebcdic=1 they are SYN=0x32, EOT=0x37, ENQ=0x2D. SOH=0x01 and STX=0x02 in both sets.
- R10: An abort during pads, SYN pair, data or check bytes lets the byte handed over in that cycle complete. The next bytes are EOT and then 0xFF, and the line returns to idle. No check byte is sent.
- R11: An abort while idle with no FIFO data, or during the trailing pad, has no effect on the output stream.
- R12: While out_ready is 0, out_data holds its value. The exceptions are the idle and data phases, where the FIFO or the configuration may change the offered byte, and the abort cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_idle_syn | input | 1 | 1: idle with SYN, 0: idle with mark (0xFF) |
| cfg_pad_cnt | input | PAD_W | Leading pad count in mark idle |
| cfg_pad_zero | input | 1 | Pad value: 0 gives 0xAA, 1 gives 0x00 |
| cfg_ebcdic | input | 1 | Control code set: 0 ASCII, 1 EBCDIC |
| cfg_lrc | input | 1 | Check type: 1 LRC, 0 CRC-16 |
| in_valid | input | 1 | FIFO holds a byte |
| in_data | input | 8 | FIFO head byte |
| in_eof | input | 1 | FIFO head byte ends the frame |
| in_ready | output | 1 | FIFO head byte is taken this cycle |
| abort | input | 1 | One-cycle abort strobe |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Serializer takes out_data |
| out_data | output | 8 | Output character |

## Verification
The framer is driven with several frame shapes. Each one separates a different part of the content rule:
- A plain STX…ETX frame with LRC in mark idle with AA pads.
- A header frame (SOH…STX…ETX) with an embedded SYN and CRC in SYN idle with a non-zero pad count, which shows that pads are skipped, SYN is excluded and the CRC byte order is right.
- EBCDIC frames that end in ETX, EOT and ENQ, which expose a wrong code set and a wrong ending choice.
- A frame with no SOH or STX.

A FIFO underrun followed by an abort, and an abort while idle, separate the abort path from normal closing. A backpressured run of the CRC frame must match its free-running result.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PAD,
      ST_SYN1,
      ST_SYN2,
      ST_DATA,
      ST_BCC0,
      ST_BCC1,
      ST_TPAD,
      ST_ABT
   } bsc_st_e;

   typedef struct packed {
      logic [7:0] syn;
      logic [7:0] eot;
      logic [7:0] enq;
      logic [7:0] soh;
      logic [7:0] stx;
   } bsc_codes_t;

   localparam logic [7:0] MARK_BYTE  = 8'hFF;
   localparam logic [7:0] TRAIL_BYTE = 8'hFF;
   localparam logic [7:0] PAD_ALT    = 8'hAA;
   localparam logic [7:0] PAD_NONE   = 8'h00;

endpackage

// File: rtl/bsc_codes.sv
module bsc_codes
   import bsc_pkg::*;
(
   input  logic       ebcdic,
   output bsc_codes_t codes
);

   always_comb begin
      codes.soh = 8'h01;
      codes.stx = 8'h02;
      if (ebcdic) begin
         codes.syn = 8'h32;
         codes.eot = 8'h37;
         codes.enq = 8'h2D;
      end else begin
         codes.syn = 8'h16;
         codes.eot = 8'h04;
         codes.enq = 8'h05;
      end
   end

endmodule

// File: rtl/bsc_bcc.sv
module bsc_bcc #(
   parameter bit          CRC_EN       = 1'b1,
   parameter logic [15:0] CRC_POLY_REV = 16'hA001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic        use_lrc,
   input  logic [7:0]  din,
   output logic [15:0] bcc_o
);

   logic [7:0] lrc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) lrc_q <= 8'h00;
      else if (en)       lrc_q <= lrc_q ^ din;
   end

   generate
      if (CRC_EN) begin : g_crc
         logic [15:0] crc_q;

         function automatic logic [15:0] crc_step(input logic [15:0] c,
                                                  input logic [7:0]  d);
            logic [15:0] r;
            r = c ^ {8'h00, d};
            for (int i = 0; i < 8; i++)
               r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
            return r;
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n || clr) crc_q <= 16'h0000;
            else if (en)       crc_q <= crc_step(crc_q, din);
         end

         assign bcc_o = use_lrc ? {8'h00, lrc_q} : crc_q;
      end else begin : g_lrc_only
         logic unused_sel;
         assign unused_sel = use_lrc;
         assign bcc_o      = {8'h00, lrc_q};
      end
   endgenerate

endmodule

// File: rtl/bsc_pad_cnt.sv
module bsc_pad_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= load_val;
      else if (dec && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
   end

   assign last = (cnt_q == W'(1));

endmodule

// File: rtl/bsc_tx_framer.sv
module bsc_tx_framer
   import bsc_pkg::*;
#(
   parameter int          PAD_W        = 4,
   parameter bit          CRC_EN       = 1'b1,
   parameter logic [15:0] CRC_POLY_REV = 16'hA001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_idle_syn,
   input  logic [PAD_W-1:0] cfg_pad_cnt,
   input  logic             cfg_pad_zero,
   input  logic             cfg_ebcdic,
   input  logic             cfg_lrc,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_eof,
   output logic             in_ready,
   input  logic             abort,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data
);

   if (PAD_W < 1 || PAD_W > 8) begin : g_chk_pad_w
      $error("bsc_tx_framer: PAD_W must lie in 1..8");
   end
   if (CRC_EN && CRC_POLY_REV == 16'h0000) begin : g_chk_poly
      $error("bsc_tx_framer: CRC polynomial must be non-zero");
   end

   bsc_st_e     st_q, st_d;
   logic        vld_q;
   logic        bcc_on_q;
   bsc_codes_t  cd;
   logic [15:0] bcc;
   logic        pad_last;
   logic        fire, take, in_frame, eff_lrc;
   logic        is_syn, is_start, is_ctl_end;

   bsc_codes i_codes (
      .ebcdic (cfg_ebcdic),
      .codes  (cd)
   );

   assign fire       = out_valid && out_ready;
   assign in_ready   = (st_q == ST_DATA) && out_ready && vld_q;
   assign take       = in_ready && in_valid;
   assign in_frame   = st_q inside {ST_PAD, ST_SYN1, ST_SYN2, ST_DATA, ST_BCC0, ST_BCC1};
   assign eff_lrc    = cfg_lrc || !CRC_EN;
   assign is_syn     = (in_data == cd.syn);
   assign is_start   = (in_data == cd.soh) || (in_data == cd.stx);
   assign is_ctl_end = (in_data == cd.eot) || (in_data == cd.enq);
   assign out_valid  = vld_q;

   bsc_pad_cnt #(.W(PAD_W)) i_pad (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fire && st_q == ST_IDLE),
      .load_val (cfg_pad_cnt),
      .dec      (fire && st_q == ST_PAD),
      .last     (pad_last)
   );

   bsc_bcc #(.CRC_EN(CRC_EN), .CRC_POLY_REV(CRC_POLY_REV)) i_bcc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (st_q == ST_IDLE),
      .en      (take && bcc_on_q && !is_syn),
      .use_lrc (eff_lrc),
      .din     (in_data),
      .bcc_o   (bcc)
   );

   always_comb begin
      unique case (st_q)
         ST_IDLE:          out_data = cfg_idle_syn ? cd.syn : MARK_BYTE;
         ST_PAD:           out_data = cfg_pad_zero ? PAD_NONE : PAD_ALT;
         ST_SYN1, ST_SYN2: out_data = cd.syn;
         ST_DATA:          out_data = in_valid ? in_data : cd.syn;
         ST_BCC0:          out_data = bcc[7:0];
         ST_BCC1:          out_data = bcc[15:8];
         ST_TPAD:          out_data = TRAIL_BYTE;
         ST_ABT:           out_data = cd.eot;
         default:          out_data = MARK_BYTE;
      endcase
   end

   always_comb begin
      st_d = st_q;
      if (abort && in_frame) begin
         st_d = ST_ABT;
      end else if (fire) begin
         unique case (st_q)
            ST_IDLE:
               if (in_valid)
                  st_d = (!cfg_idle_syn && cfg_pad_cnt != '0) ? ST_PAD : ST_SYN1;
            ST_PAD:  if (pad_last) st_d = ST_SYN1;
            ST_SYN1: st_d = ST_SYN2;
            ST_SYN2: st_d = ST_DATA;
            ST_DATA:
               if (in_valid && in_eof)
                  st_d = (is_ctl_end || !bcc_on_q) ? ST_TPAD : ST_BCC0;
            ST_BCC0: st_d = eff_lrc ? ST_TPAD : ST_BCC1;
            ST_BCC1: st_d = ST_TPAD;
            ST_TPAD: st_d = ST_IDLE;
            ST_ABT:  st_d = ST_TPAD;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         vld_q    <= 1'b0;
         bcc_on_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         vld_q <= 1'b1;
         if (st_q == ST_IDLE)       bcc_on_q <= 1'b0;
         else if (take && is_start) bcc_on_q <= 1'b1;
      end
   end

endmodule

// File: rtl/bsc_tx_framer_chk.sv
module bsc_tx_framer_chk
   import bsc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_ebcdic,
   input logic       in_valid,
   input logic [7:0] in_data,
   input logic       in_ready,
   input logic       abort,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input bsc_st_e    st
);

   logic [7:0] syn_c, eot_c;
   logic       frm;
   assign syn_c = cfg_ebcdic ? 8'h32 : 8'h16;
   assign eot_c = cfg_ebcdic ? 8'h37 : 8'h04;
   assign frm   = st inside {ST_PAD, ST_SYN1, ST_SYN2, ST_DATA, ST_BCC0, ST_BCC1};

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !in_ready));  // R1

   AST_VALID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> out_valid);  // R1

   AST_TAKE_IS_SENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid) |-> (out_valid && out_data == in_data));  // R4

   AST_SYN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SYN1 && out_ready && !abort) |=> (st == ST_SYN2 && out_data == syn_c));  // R4

   AST_ABORT_EOT: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && frm) |=> (out_data == eot_c));  // R10

   AST_ABORT_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && st == ST_IDLE && !in_valid) |=> (st == ST_IDLE));  // R11

   AST_TRAIL_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TPAD) |-> (out_data == 8'hFF));  // R8

   AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !abort && st != ST_IDLE && st != ST_DATA)
         |=> $stable(out_data));  // R12

endmodule

bind bsc_tx_framer bsc_tx_framer_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_ebcdic (cfg_ebcdic),
   .in_valid   (in_valid),
   .in_data    (in_data),
   .in_ready   (in_ready),
   .abort      (abort),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .st         (st_q)
);

// File: tb/test_bsc_tx_framer.sv
module test_bsc_tx_framer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_idle_syn = 1'b0;
   logic [3:0] cfg_pad_cnt = 4'd0;
   logic       cfg_pad_zero = 1'b0;
   logic       cfg_ebcdic = 1'b0;
   logic       cfg_lrc = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_eof = 1'b0;
   logic       in_ready;
   logic       abort = 1'b0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_data;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int phase = 0;
   logic bp_en = 1'b0;
   logic took = 1'b0;

   logic [7:0] fifo_d[$];
   logic       fifo_e[$];
   logic [7:0] cap[$];

   always #5 clk = ~clk;

   bsc_tx_framer i_bsc_tx_framer (
      .clk(clk), .rst_n(rst_n), .cfg_idle_syn(cfg_idle_syn), .cfg_pad_cnt(cfg_pad_cnt),
      .cfg_pad_zero(cfg_pad_zero), .cfg_ebcdic(cfg_ebcdic), .cfg_lrc(cfg_lrc),
      .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof), .in_ready(in_ready),
      .abort(abort), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic refresh();
      if (fifo_d.size() > 0) begin
         in_valid = 1'b1; in_data = fifo_d[0]; in_eof = fifo_e[0];
      end else begin
         in_valid = 1'b0; in_data = 8'h00; in_eof = 1'b0;
      end
   endtask

   always @(negedge clk) begin
      took = in_valid && in_ready;
      if (out_valid && out_ready) cap.push_back(out_data);
   end

   always @(posedge clk) begin
      #1;
      if (took && fifo_d.size() > 0) begin
         void'(fifo_d.pop_front());
         void'(fifo_e.pop_front());
      end
      phase++;
      out_ready = bp_en ? (phase % 3 != 0) : 1'b1;
      refresh();
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
         summary();
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(logic [7:0] b, logic e);
      fifo_d.push_back(b); fifo_e.push_back(e);
      refresh();
   endtask

   function automatic logic [15:0] crc_of(logic [7:0] b[$]);
      logic [15:0] c = 16'h0000;
      foreach (b[n]) begin
         for (int i = 0; i < 8; i++) begin
            logic fb = c[0] ^ b[n][i];
            c = c >> 1;
            if (fb) c = c ^ 16'hA001;
         end
      end
      return c;
   endfunction

   task automatic frame_check(string tag, logic [7:0] idle, logic [7:0] ex[$]);
      int k = 0;
      int mism = 0;
      logic [7:0] fa = 8'h00, fe = 8'h00;
      repeat (60) tick();
      while (k < cap.size() && cap[k] == idle) k++;
      chk({tag, " frame length"}, 32'(cap.size() > k + ex.size()), 32'd1);
      if (cap.size() > k + ex.size()) begin
         foreach (ex[i]) begin
            if (cap[k+i] != ex[i]) begin
               if (mism == 0) begin fa = cap[k+i]; fe = ex[i]; end
               mism++;
            end
         end
         chk({tag, " first differing byte"}, {24'd0, fa}, {24'd0, fe});
         chk({tag, " byte mismatches"}, 32'(mism), 32'd0);
         chk({tag, " R8 back to idle"}, {24'd0, cap[k+ex.size()]}, {24'd0, idle});
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      @(negedge clk);
      chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
      chk("R1 in_ready in reset", 32'(in_ready), 32'd0);
      tick(); rst_n = 1'b1;
      repeat (2) tick();
      @(negedge clk);
      chk("R1 out_valid after reset", 32'(out_valid), 32'd1);
      chk("R2 mark idle byte", {24'd0, out_data}, 32'hFF);
      chk("R4 in_ready low while idle", 32'(in_ready), 32'd0);
      tick(); cfg_idle_syn = 1'b1; tick();
      @(negedge clk);
      chk("R2 SYN idle byte ASCII", {24'd0, out_data}, 32'h16);
      tick(); cfg_ebcdic = 1'b1; tick();
      @(negedge clk);
      chk("R9 SYN idle byte EBCDIC", {24'd0, out_data}, 32'h32);
      tick(); cfg_ebcdic = 1'b0; cfg_idle_syn = 1'b0; tick();
   endtask

   task automatic t_lrc_mark();
      logic [7:0] ex[$];
      cfg_idle_syn = 1'b0; cfg_pad_cnt = 4'd3; cfg_pad_zero = 1'b0;
      cfg_ebcdic = 1'b0; cfg_lrc = 1'b1;
      tick(); cap.delete();
      push(8'h02, 0); push(8'h48, 0); push(8'h69, 0); push(8'h03, 1);
      ex = {8'hAA, 8'hAA, 8'hAA, 8'h16, 8'h16, 8'h02, 8'h48, 8'h69, 8'h03, 8'h22, 8'hFF};
      frame_check("R3 R5 R6 LRC frame with AA pads", 8'hFF, ex);
   endtask

   task automatic t_crc_syn(logic bp);
      logic [7:0] ex[$];
      logic [7:0] cov[$];
      logic [15:0] c;
      cfg_idle_syn = 1'b1; cfg_pad_cnt = 4'd3; cfg_ebcdic = 1'b0; cfg_lrc = 1'b0;
      bp_en = bp;
      tick(); cap.delete();
      push(8'h01, 0); push(8'h48, 0); push(8'h02, 0); push(8'h44, 0);
      push(8'h16, 0); push(8'h45, 0); push(8'h03, 1);
      cov = {8'h48, 8'h02, 8'h44, 8'h45, 8'h03};
      c = crc_of(cov);
      ex = {8'h01, 8'h48, 8'h02, 8'h44, 8'h16, 8'h45, 8'h03, c[7:0], c[15:8], 8'hFF};
      if (bp) frame_check("R12 R7 CRC frame under backpressure", 8'h16, ex);
      else    frame_check("R3 R4 R5 R7 CRC frame, SYN idle, embedded SYN", 8'h16, ex);
      bp_en = 1'b0;
      tick();
   endtask

   task automatic t_ebcdic();
      logic [7:0] ex[$];
      cfg_idle_syn = 1'b0; cfg_pad_cnt = 4'd2; cfg_pad_zero = 1'b1;
      cfg_ebcdic = 1'b1; cfg_lrc = 1'b1;
      tick(); cap.delete();
      push(8'h02, 0); push(8'hC1, 0); push(8'h32, 0); push(8'hC4, 0); push(8'h03, 1);
      ex = {8'h00, 8'h00, 8'h32, 8'h32, 8'h02, 8'hC1, 8'h32, 8'hC4, 8'h03, 8'h06, 8'hFF};
      frame_check("R9 R3 EBCDIC LRC frame with zero pads", 8'hFF, ex);
      cap.delete();
      push(8'h02, 0); push(8'hC1, 0); push(8'h37, 1);
      ex = {8'h00, 8'h00, 8'h32, 8'h32, 8'h02, 8'hC1, 8'h37, 8'hFF};
      frame_check("R8 R9 EBCDIC EOT ending", 8'hFF, ex);
      cap.delete();
      push(8'h2D, 1);
      ex = {8'h00, 8'h00, 8'h32, 8'h32, 8'h2D, 8'hFF};
      frame_check("R8 R9 EBCDIC ENQ frame", 8'hFF, ex);
   endtask

   task automatic t_no_start();
      logic [7:0] ex[$];
      cfg_idle_syn = 1'b0; cfg_pad_cnt = 4'd0; cfg_ebcdic = 1'b0; cfg_lrc = 1'b1;
      tick(); cap.delete();
      push(8'h41, 0); push(8'h42, 1);
      ex = {8'h16, 8'h16, 8'h41, 8'h42, 8'hFF};
      frame_check("R8 frame without SOH/STX has no check", 8'hFF, ex);
   endtask

   task automatic t_abort();
      logic [7:0] ex[$];
      cfg_idle_syn = 1'b0; cfg_pad_cnt = 4'd0; cfg_ebcdic = 1'b0; cfg_lrc = 1'b1;
      tick();
      push(8'h02, 0); push(8'h61, 0); push(8'h62, 0);
      repeat (20) tick();
      @(negedge clk);
      chk("R4 SYN fill on FIFO underrun", {24'd0, out_data}, 32'h16);
      tick(); cap.delete(); abort = 1'b1;
      tick(); abort = 1'b0;
      repeat (5) tick();
      chk("R10 abort capture length", 32'(cap.size() >= 4), 32'd1);
      if (cap.size() >= 4) begin
         chk("R10 byte in abort cycle", {24'd0, cap[0]}, 32'h16);
         chk("R10 EOT after abort", {24'd0, cap[1]}, 32'h04);
         chk("R10 trailing pad after abort", {24'd0, cap[2]}, 32'hFF);
         chk("R10 idle after abort", {24'd0, cap[3]}, 32'hFF);
      end
      cap.delete(); abort = 1'b1;
      tick(); abort = 1'b0;
      repeat (4) tick();
      foreach (cap[i]) chk("R11 abort in idle leaves mark", {24'd0, cap[i]}, 32'hFF);
      cap.delete();
      push(8'h05, 1);
      ex = {8'h16, 8'h16, 8'h05, 8'hFF};
      frame_check("R11 frame after idle abort is normal", 8'hFF, ex);
   endtask

   initial begin
      t_reset();
      t_lrc_mark();
      t_crc_syn(1'b0);
      t_ebcdic();
      t_no_start();
      t_crc_syn(1'b1);
      t_abort();
      summary();
      $finish;
   end

endmodule